// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is an 8-bit serial port in which a transmitter and a receiver work at the same time on one shared serial clock. The clock is produced in one of two ways. An internal divider can generate it, and the block then drives it out on the clock pin. Otherwise an outside device supplies it on that pin and the block only watches it. Each character carries eight data bits and nothing else. Data leaves on the falling clock edge and is taken in on the rising edge.

Each direction has a holding register in front of its shift register. Software-side logic can write the next byte while the current one is still shifting out, and it can read the last received byte while the next one is being assembled. When the next byte is already waiting, characters follow each other with no idle time on the clock. The parallel side has single-cycle write and read strobes and three flags: transmit register empty, receive full and receive overrun.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, `sck_o` is high, `sck_oe` is high while `cfg_ext_clk` is 0, `tx_empty` is 1, and `rx_full` and `rx_overrun` are 0.
- R2: A character is exactly 8 data bits, sent least significant bit first, with no start, stop or parity bit. With the internal clock, exactly 8 rising clock edges are driven per character.
- R3: With the internal clock, `sd_o` changes only in the cycle in which `sck_o` falls. It therefore stays stable from one falling edge to the next.
- R4: The receiver shifts in `sd_i` on each rising edge of the serial clock, least significant bit first.
- R5: After the eighth bit, `sd_o` keeps the value of bit 7 of that character until the next character starts.
- R6: With `cfg_ext_clk` = 0, each clock phase lasts `cfg_div`+1 system clocks, so one bit takes 2*(`cfg_div`+1) system clocks. The clock stays high while no character is in flight.
- R7: If a byte is waiting in the transmit holding register when a character ends, the next character follows at once. The rising edges of both characters are then evenly spaced at the bit period.
- R8: `tx_empty` goes to 0 in the cycle after an accepted `tx_write` and returns to 1 when the byte moves into the shift register. A `tx_write` while `tx_empty` is 0 is ignored.
- R9: After the eighth received bit, `rx_full` is 1 and `rx_rdata` holds the byte. `rx_read` clears `rx_full`.
- R10: If a byte completes while `rx_full` is 1 and no read is made in that cycle, `rx_overrun` becomes 1 and `rx_rdata` keeps the unread byte. `rx_read` clears both flags.
- R11: With `cfg_ext_clk` = 1, `sck_oe` is 0. The block then shifts `sd_o` on synchronised falling edges of `sck_i` and samples `sd_i` on its synchronised rising edges.
- R12: Transmitter and receiver run at the same time on the shared clock. A byte looped from `sd_o` back to `sd_i` arrives intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_clk | input | 1 | 0: internal divider clock driven out; 1: external clock on sck_i |
| cfg_div | input | DIV_W | Half-period divider value N (N+1 system clocks per phase) |
| tx_write | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit holding register can take a byte |
| rx_read | input | 1 | Read strobe, clears the receive flags |
| rx_rdata | output | 8 | Last received byte |
| rx_full | output | 1 | A received byte is waiting |
| rx_overrun | output | 1 | A byte completed while the previous one was unread |
| sck_i | input | 1 | Serial clock input (external mode) |
| sck_o | output | 1 | Serial clock output (internal mode) |
| sck_oe | output | 1 | Output enable for the clock pin |
| sd_i | input | 1 | Serial receive data |
| sd_o | output | 1 | Serial transmit data |

## Verification
Two situations are hard to reach from the ports. Both depend on a write or a read landing while a shift register is still busy. Gapless transmission needs the second byte written in the short window after the first byte leaves the holding register and before its eighth bit ends. The bench therefore writes two cycles after the first strobe, measures the spacing of all sixteen rising edges, and reads the first looped-back byte before the second one finishes. Overrun is reached by leaving a received byte unread and sending another one. The ignored write is forced in external mode, where no clock runs, so the holding register stays full long enough for a second strobe to hit it.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam cnt_t BITS_DONE = cnt_t'(BYTE_W);
    localparam cnt_t BIT_LAST  = cnt_t'(BYTE_W - 1);

    typedef struct packed {
        byte_t hold;
        logic  hold_vld;
        byte_t shift;
        cnt_t  bits;
        logic  sd;
        logic  sck;
        logic  busy;
    } tx_st_t;

    typedef struct packed {
        byte_t shift;
        cnt_t  cnt;
        byte_t data;
        logic  full;
        logic  ovr;
    } rx_st_t;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             sck_i,
    output logic             tick,
    output logic             ext_rise,
    output logic             ext_fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [SYNC_N:0]  sync;
    } cg_st_t;

    cg_st_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_N-1:0], sck_i};
        tick   = run && (q.cnt == div);
        if (!run || tick) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    assign ext_rise = q.sync[SYNC_N-1] & ~q.sync[SYNC_N];
    assign ext_fall = ~q.sync[SYNC_N-1] & q.sync[SYNC_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.sync <= '1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
    import ssp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ext_mode,
    input  logic  tick,
    input  logic  ext_rise,
    input  logic  ext_fall,
    input  logic  wr,
    input  byte_t wdata,
    output logic  sd,
    output logic  sck,
    output logic  busy,
    output logic  empty,
    output logic  rise_ev
);
    tx_st_t q, d;
    logic   load;

    always_comb begin
        d       = q;
        rise_ev = 1'b0;
        load    = 1'b0;
        if (wr && !q.hold_vld) begin
            d.hold     = wdata;
            d.hold_vld = 1'b1;
        end
        if (ext_mode) begin
            d.sck = 1'b1;
            if (ext_rise && q.busy && q.bits != BITS_DONE) begin
                d.bits = q.bits + 1'b1;
            end
            if (ext_fall) begin
                if (!q.busy || q.bits == BITS_DONE) begin
                    load   = q.hold_vld;
                    d.busy = q.hold_vld;
                end else begin
                    d.shift = q.shift >> 1;
                    d.sd    = q.shift[1];
                end
            end
        end else if (!q.busy) begin
            load   = q.hold_vld;
            d.busy = q.hold_vld;
        end else if (tick) begin
            if (!q.sck) begin
                d.sck   = 1'b1;
                d.bits  = q.bits + 1'b1;
                rise_ev = 1'b1;
            end else if (q.bits == BITS_DONE) begin
                load   = q.hold_vld;
                d.busy = q.hold_vld;
            end else begin
                d.shift = q.shift >> 1;
                d.sd    = q.shift[1];
                d.sck   = 1'b0;
            end
        end
        if (load) begin
            d.shift    = q.hold;
            d.sd       = q.hold[0];
            d.bits     = '0;
            d.hold_vld = 1'b0;
            d.sck      = ext_mode;
        end
    end

    assign sd    = q.sd;
    assign sck   = q.sck;
    assign busy  = q.busy;
    assign empty = ~q.hold_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{hold: '0, hold_vld: 1'b0, shift: '0, bits: '0,
                   sd: 1'b0, sck: 1'b1, busy: 1'b0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
    import ssp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rise,
    input  logic  sd,
    input  logic  rd,
    output byte_t data,
    output logic  full,
    output logic  ovr
);
    rx_st_t q, d;
    byte_t  nxt;

    always_comb begin
        d   = q;
        nxt = {sd, q.shift[BYTE_W-1:1]};
        if (rd) begin
            d.full = 1'b0;
            d.ovr  = 1'b0;
        end
        if (rise) begin
            d.shift = nxt;
            if (q.cnt == BIT_LAST) begin
                d.cnt = '0;
                if (q.full && !rd) begin
                    d.ovr = 1'b1;
                end else begin
                    d.data = nxt;
                    d.full = 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    assign data = q.data;
    assign full = q.full;
    assign ovr  = q.ovr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ext_clk,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             tx_write,
    input  logic [7:0]       tx_wdata,
    output logic             tx_empty,
    input  logic             rx_read,
    output logic [7:0]       rx_rdata,
    output logic             rx_full,
    output logic             rx_overrun,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             sck_oe,
    input  logic             sd_i,
    output logic             sd_o
);
    logic tick, ext_rise, ext_fall;
    logic tx_busy, tx_sck, tx_rise;
    logic rx_rise;

    ssp_clkgen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tx_busy & ~cfg_ext_clk),
        .div      (cfg_div),
        .sck_i    (sck_i),
        .tick     (tick),
        .ext_rise (ext_rise),
        .ext_fall (ext_fall)
    );

    ssp_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_mode (cfg_ext_clk),
        .tick     (tick),
        .ext_rise (ext_rise),
        .ext_fall (ext_fall),
        .wr       (tx_write),
        .wdata    (tx_wdata),
        .sd       (sd_o),
        .sck      (tx_sck),
        .busy     (tx_busy),
        .empty    (tx_empty),
        .rise_ev  (tx_rise)
    );

    assign rx_rise = cfg_ext_clk ? ext_rise : tx_rise;

    ssp_rx u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rx_rise),
        .sd    (sd_i),
        .rd    (rx_read),
        .data  (rx_rdata),
        .full  (rx_full),
        .ovr   (rx_overrun)
    );

    assign sck_o  = tx_sck;
    assign sck_oe = ~cfg_ext_clk;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_ext_clk,
    input logic [DIV_W-1:0] cfg_div,
    input logic             tx_write,
    input logic             tx_empty,
    input logic             rx_read,
    input logic [7:0]       rx_rdata,
    input logic             rx_full,
    input logic             rx_overrun,
    input logic             sck_o,
    input logic             sd_o
);
    a_r3_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ext_clk && $past(!cfg_ext_clk) && !$stable(sd_o)) |-> $fell(sck_o));

    a_r6_low_phase_lasts: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ext_clk && $fell(sck_o) && cfg_div != '0) |=> !sck_o);

    a_r8_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_write && tx_empty) |=> !tx_empty);

    a_r10_unread_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !rx_read) |=> ($stable(rx_rdata) && rx_overrun));

    a_r10_overrun_implies_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_full);
endmodule

bind sync_serial_port ssp_checker #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ext_clk (cfg_ext_clk),
    .cfg_div     (cfg_div),
    .tx_write    (tx_write),
    .tx_empty    (tx_empty),
    .rx_read     (rx_read),
    .rx_rdata    (rx_rdata),
    .rx_full     (rx_full),
    .rx_overrun  (rx_overrun),
    .sck_o       (sck_o),
    .sd_o        (sd_o)
);

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ext_clk = 1'b0;
    logic [7:0] cfg_div = 8'd2;
    logic       tx_write = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic       tx_empty;
    logic       rx_read = 1'b0;
    logic [7:0] rx_rdata;
    logic       rx_full, rx_overrun;
    logic       bsck = 1'b1;
    logic       bsd = 1'b0;
    logic       loop = 1'b1;
    logic       sck_o, sck_oe, sd_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rise_t[$];
    logic [7:0] line_q[$];
    logic [7:0] line_sh = 8'h00;
    int   line_n = 0;
    logic prev_sck = 1'b1;
    logic prev_sd = 1'b0;
    logic [7:0] seen;

    always #2 clk = ~clk;

    sync_serial_port dut (
        .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_div(cfg_div),
        .tx_write(tx_write), .tx_wdata(tx_wdata), .tx_empty(tx_empty),
        .rx_read(rx_read), .rx_rdata(rx_rdata), .rx_full(rx_full),
        .rx_overrun(rx_overrun), .sck_i(bsck), .sck_o(sck_o), .sck_oe(sck_oe),
        .sd_i(loop ? sd_o : bsd), .sd_o(sd_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic line_chk(input string req, input logic [7:0] exp);
        if (line_q.size() == 0) begin
            chk(req, 32'hdead, {24'h0, exp});
        end else begin
            chk(req, {24'h0, line_q.pop_front()}, {24'h0, exp});
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        tx_wdata = b; tx_write = 1'b1;
        @(negedge clk);
        tx_write = 1'b0;
    endtask

    task automatic rd();
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
    endtask

    task automatic wait_rises(input int k);
        while (rise_t.size() < k) @(negedge clk);
    endtask

    task automatic ext_byte(input logic [7:0] mdata, output logic [7:0] got);
        got = 8'h00;
        for (int i = 0; i < 8; i++) begin
            bsck = 1'b0; bsd = mdata[i];
            step(8);
            bsck = 1'b1;
            step(4);
            got[i] = sd_o;
            step(4);
        end
    endtask

    // behavioural line model: watches the pins every clock in internal mode
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !cfg_ext_clk) begin
            if (sd_o !== prev_sd) begin
                checks++;
                if (!(prev_sck === 1'b1 && sck_o === 1'b0)) begin
                    fails++;
                    $display("FAIL R3 sd_o changed without falling clock: sck actual=%0b expected=0", sck_o);
                end
            end
            if (prev_sck === 1'b0 && sck_o === 1'b1) begin
                rise_t.push_back(cyc);
                line_sh = {sd_o, line_sh[7:1]};
                line_n++;
                if (line_n == 8) begin
                    line_q.push_back(line_sh);
                    line_n = 0;
                end
            end
        end
        prev_sck = sck_o;
        prev_sd  = sd_o;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        step(3);
        chk("R1 sck_o idle", sck_o, 1);
        chk("R1 sck_oe", sck_oe, 1);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 rx_overrun", rx_overrun, 0);
        rst_n = 1'b1;
        step(2);

        // single character, loopback
        rise_t.delete();
        wr(8'hA5);
        wait_rises(8);
        step(4);
        line_chk("R2 line byte LSB first", 8'hA5);
        chk("R4 R12 rx_rdata loopback", rx_rdata, 8'hA5);
        chk("R9 rx_full set", rx_full, 1);
        chk("R8 tx_empty after load", tx_empty, 1);
        step(30);
        chk("R2 eight pulses only", rise_t.size(), 8);
        chk("R6 rise spacing", rise_t[7] - rise_t[0], 7 * 6);
        chk("R6 idle high", sck_o, 1);
        chk("R5 hold MSB 1", sd_o, 1);
        rd();
        chk("R9 read clears full", rx_full, 0);

        // back to back
        rise_t.delete();
        wr(8'h3C);
        step(2);
        chk("R8 emptied by load", tx_empty, 1);
        wr(8'hC3);
        chk("R8 second byte waiting", tx_empty, 0);
        wait_rises(8);
        step(3);
        chk("R9 first of pair", rx_rdata, 8'h3C);
        rd();
        wait_rises(16);
        step(4);
        chk("R7 sixteen rises", rise_t.size(), 16);
        chk("R7 no gap", rise_t[15] - rise_t[0], 15 * 6);
        chk("R7 mid spacing", rise_t[8] - rise_t[7], 6);
        line_chk("R7 line first", 8'h3C);
        line_chk("R7 line second", 8'hC3);
        chk("R12 second received", rx_rdata, 8'hC3);
        chk("R10 no overrun", rx_overrun, 0);

        // overrun
        wr(8'h7E);
        wait_rises(24);
        step(4);
        chk("R10 overrun set", rx_overrun, 1);
        chk("R10 unread byte kept", rx_rdata, 8'hC3);
        chk("R10 full stays", rx_full, 1);
        line_chk("R2 line 7E", 8'h7E);
        step(20);
        chk("R5 hold MSB 0", sd_o, 0);
        chk("R6 idle high after", sck_o, 1);
        rd();
        chk("R10 read clears overrun", rx_overrun, 0);
        chk("R10 read clears full", rx_full, 0);

        // divider settings
        cfg_div = 8'd0;
        rise_t.delete();
        wr(8'h81);
        wait_rises(8);
        step(4);
        chk("R6 div 0 spacing", rise_t[7] - rise_t[0], 7 * 2);
        line_chk("R2 line 81", 8'h81);
        chk("R12 rx 81", rx_rdata, 8'h81);
        rd();
        cfg_div = 8'd5;
        rise_t.delete();
        wr(8'h5A);
        wait_rises(8);
        step(4);
        chk("R6 div 5 spacing", rise_t[7] - rise_t[0], 7 * 12);
        line_chk("R2 line 5A", 8'h5A);
        chk("R12 rx 5A", rx_rdata, 8'h5A);
        rd();
        step(20);

        // external clock
        cfg_ext_clk = 1'b1;
        loop = 1'b0;
        step(2);
        chk("R11 clock pin released", sck_oe, 0);
        wr(8'h11);
        wr(8'h22);
        chk("R8 holding full", tx_empty, 0);
        ext_byte(8'h96, seen);
        step(6);
        chk("R8 R11 ignored write, line 11", seen, 8'h11);
        chk("R4 R11 rx external", rx_rdata, 8'h96);
        chk("R11 rx_full", rx_full, 1);
        chk("R8 empty after ext load", tx_empty, 1);
        rd();
        ext_byte(8'hF0, seen);
        step(6);
        chk("R5 R8 line holds MSB, 22 never sent", seen, 8'h00);
        chk("R11 rx second external", rx_rdata, 8'hF0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule